// File: doc/BRIEF.md
# Configurable PLD Output Cell

This block is one output cell of a programmable logic device. Up to eight product-term inputs arrive from the AND array. Each term has an enable bit and a group bit. The enabled terms in group 0 are ORed into a primary sum. The enabled terms in group 1 are ORed into a secondary sum. A static configuration word then decides what happens to those sums. They can drive the pin with no register at all, or they can feed a storage element. That element can be a D, T, SR or JK flip-flop, or a level-sensitive latch.

An optional inverter sits between the stored value and the pin. A feedback output returns one of three signals to the array: the register value, the pad value, or the primary sum corrected to pin polarity. The pin is modelled as a value plus a drive enable, so the three-state buffer itself stays outside the block. The configuration may change only while the asynchronous clear is asserted.

Top module: `pld_out_cell`

## Requirements
- R1: The primary sum is the OR of every term whose enable bit is 1 and group bit is 0. The secondary sum is the OR of every term whose enable bit is 1 and group bit is 1. A term whose enable bit is 0 has no effect.
- R2: With `cfg_mode_i` equal to 0, 6 or 7 (pass-through), the pin follows the primary sum, after the optional inverter, with no clock.
- R3: With `cfg_mode_i`=1 (D), the register loads the primary sum on a clock edge where `ce_i` is 1.
- R4: With `cfg_mode_i`=2 (T), the register inverts on an enabled edge when the primary sum is 1, and holds when it is 0.
- R5: With `cfg_mode_i`=3 (SR), the primary sum sets and the secondary sum clears. When both are 1 the register clears. When both are 0 it holds.
- R6: With `cfg_mode_i`=4 (JK), the primary sum is J and the secondary sum is K. When both are 1 the register inverts.
- R7: With `cfg_mode_i`=5 (latch), the stored value follows the primary sum while `gate_i` equals `cfg_gate_pol_i`, and holds otherwise. The synchronous controls do not touch the latch.
- R8: `arst_i` clears the stored value at once and wins over `apre_i`. `apre_i` alone sets the stored value at once.
- R9: On a clock edge, `rst_n` low clears the flip-flop. After that, `srst_i` clears it, then `spre_i` sets it, and both of these win over data capture.
- R10: With `ce_i` at 0 and no reset or preset active, a clocked-mode register holds its value across edges.
- R11: When `cfg_invert_i` is 1, `pin_o` is the complement of the stored value (or of the sum in pass-through).
- R12: `cfg_fb_sel_i` selects `fb_o`: 0 or 3 gives the stored value at register polarity, 1 gives `pad_i`, and 2 gives the primary sum XOR `cfg_invert_i`.
- R13: `pin_oe_o` equals `oe_i`, so `oe_i` at 0 puts the pin in high impedance.
- R14: In D mode with register feedback, drive term 0 with the inverted feedback ANDed with a toggle input. The pin then alternates every clock while the toggle is 1, and settles at 0 once the toggle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flip-flop |
| cfg_mode_i | input | 3 | Storage mode select |
| cfg_term_en_i | input | NUM_TERMS | Per-term enable bits |
| cfg_term_grp_i | input | NUM_TERMS | Per-term group: 0 primary, 1 secondary |
| cfg_invert_i | input | 1 | Output inverter on |
| cfg_fb_sel_i | input | 2 | Feedback source select |
| cfg_gate_pol_i | input | 1 | Latch gate active level |
| terms_i | input | NUM_TERMS | Product-term inputs |
| ce_i | input | 1 | Clock enable |
| gate_i | input | 1 | Latch gate |
| arst_i | input | 1 | Asynchronous clear |
| apre_i | input | 1 | Asynchronous preset |
| srst_i | input | 1 | Synchronous clear |
| spre_i | input | 1 | Synchronous preset |
| oe_i | input | 1 | Output enable |
| pad_i | input | 1 | Value seen at the pad |
| pin_o | output | 1 | Value driven to the pad |
| pin_oe_o | output | 1 | Pad drive enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
The bench builds the cell with its default of eight terms. This gives each slot an independent random enable and group bit, so both sums see mixed masks, and a disabled term that is active can show whether it leaks. Random configurations sweep all eight mode codes, both latch polarities and every feedback select. A bench model of the register and the latch predicts each output. Directed cases cover the priority collisions, the SR and JK both-high cases, and the toggle loop closed through the feedback output.

// File: rtl/pld_cell_pkg.sv
// Shared encodings for the configurable output cell.
// Assumes a 3-bit mode field and a 2-bit feedback select.
package pld_cell_pkg;
    localparam logic [2:0] MODE_COMB  = 3'd0;
    localparam logic [2:0] MODE_D     = 3'd1;
    localparam logic [2:0] MODE_T     = 3'd2;
    localparam logic [2:0] MODE_SR    = 3'd3;
    localparam logic [2:0] MODE_JK    = 3'd4;
    localparam logic [2:0] MODE_LATCH = 3'd5;

    localparam logic [1:0] FB_REG  = 2'd0;
    localparam logic [1:0] FB_PAD  = 2'd1;
    localparam logic [1:0] FB_DATA = 2'd2;

    // True for the modes that use the edge-triggered register.
    function automatic logic is_clocked(input logic [2:0] mode);
        return (mode == MODE_D) || (mode == MODE_T) ||
               (mode == MODE_SR) || (mode == MODE_JK);
    endfunction

    // Next flip-flop value for one enabled edge; non-clocked modes hold.
    function automatic logic ff_next(input logic [2:0] mode, input logic q,
                                     input logic a, input logic b);
        logic n;
        case (mode)
            MODE_D:  n = a;
            MODE_T:  n = q ^ a;
            MODE_SR: n = b ? 1'b0 : (a ? 1'b1 : q);
            MODE_JK: n = (a & b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
            default: n = q;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/term_sum.sv
// Steers each enabled product term into one of two OR sums.
// Assumes the enable and group bits are static while the terms change.
module term_sum #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms_i,
    input  logic [NUM_TERMS-1:0] en_i,
    input  logic [NUM_TERMS-1:0] grp_i,
    output logic                 sum_a_o,
    output logic                 sum_b_o
);
    logic [NUM_TERMS-1:0] lane_a;
    logic [NUM_TERMS-1:0] lane_b;

    // One masking lane per term slot.
    for (genvar i = 0; i < NUM_TERMS; i++) begin : g_lane
        assign lane_a[i] = terms_i[i] & en_i[i] & ~grp_i[i];
        assign lane_b[i] = terms_i[i] & en_i[i] &  grp_i[i];
    end

    assign sum_a_o = |lane_a;
    assign sum_b_o = |lane_b;
endmodule

// File: rtl/cell_store.sv
// Storage for the cell: one edge register shared by D/T/SR/JK modes and a
// separate level latch. Asynchronous clear beats asynchronous preset; on an
// edge rst_n, then srst, then spre, then clock-enabled capture.
// Assumes the mode is changed only while arst_i is high.
module cell_store
    import pld_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       gate_pol_i,
    input  logic       sum_a_i,
    input  logic       sum_b_i,
    input  logic       ce_i,
    input  logic       gate_i,
    input  logic       arst_i,
    input  logic       apre_i,
    input  logic       srst_i,
    input  logic       spre_i,
    output logic       q_o
);
    logic ff_q;
    logic lat_q;
    logic lat_open;
    logic clocked;

    assign clocked  = is_clocked(mode_i);
    assign lat_open = (mode_i == MODE_LATCH) && (gate_i == gate_pol_i);

    // Edge register with asynchronous clear and preset.
    always_ff @(posedge clk or posedge arst_i or posedge apre_i) begin
        if (arst_i)      ff_q <= 1'b0;
        else if (apre_i) ff_q <= 1'b1;
        else if (!rst_n) ff_q <= 1'b0;
        else if (srst_i) ff_q <= 1'b0;
        else if (spre_i) ff_q <= 1'b1;
        else if (ce_i)   ff_q <= ff_next(mode_i, ff_q, sum_a_i, sum_b_i);
    end

    // Level latch, open only in latch mode at the configured gate level.
    always_latch begin
        if (arst_i)        lat_q = 1'b0;
        else if (apre_i)   lat_q = 1'b1;
        else if (lat_open) lat_q = sum_a_i;
    end

    // Present the element that the mode selects.
    assign q_o = (mode_i == MODE_LATCH) ? lat_q : ff_q;

    // R8
    arst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arst_i |-> (q_o == 1'b0));
    // R8
    apre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apre_i && !arst_i) |-> (q_o == 1'b1));
    // R9
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clocked && srst_i && !arst_i && !apre_i)
        |=> (ff_q == 1'b0 || arst_i || apre_i));
    // R9
    spre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clocked && spre_i && !srst_i && !arst_i && !apre_i)
        |=> (ff_q == 1'b1 || arst_i || apre_i));
    // R10
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clocked && !ce_i && !srst_i && !spre_i && !arst_i && !apre_i)
        |=> ($stable(ff_q) || arst_i || apre_i));
    // R3
    d_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_D && ce_i && !srst_i && !spre_i && !arst_i && !apre_i)
        |=> (ff_q == $past(sum_a_i) || arst_i || apre_i));
    // R6
    jk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_JK && ce_i && sum_a_i && sum_b_i &&
         !srst_i && !spre_i && !arst_i && !apre_i)
        |=> (ff_q != $past(ff_q) || arst_i || apre_i));
endmodule

// File: rtl/cell_out.sv
// Output stage: pass-through bypass, polarity inverter, feedback select
// and pad drive enable. Assumes a pure combinational path.
module cell_out
    import pld_cell_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       invert_i,
    input  logic [1:0] fb_sel_i,
    input  logic       sum_a_i,
    input  logic       q_i,
    input  logic       oe_i,
    input  logic       pad_i,
    output logic       pin_o,
    output logic       pin_oe_o,
    output logic       fb_o
);
    logic bypass;

    assign bypass = !is_clocked(mode_i) && (mode_i != MODE_LATCH);

    // Pin value at pin polarity.
    always_comb begin
        pin_o = (bypass ? sum_a_i : q_i) ^ invert_i;
    end

    // Feedback source select; code 3 falls back to the register.
    always_comb begin
        case (fb_sel_i)
            FB_PAD:  fb_o = pad_i;
            FB_DATA: fb_o = sum_a_i ^ invert_i;
            default: fb_o = q_i;
        endcase
    end

    assign pin_oe_o = oe_i;
endmodule

// File: rtl/pld_out_cell.sv
// Top of the configurable output cell: term steering, storage, output.
// Assumes every cfg_* input changes only while arst_i is high.
module pld_out_cell #(
    parameter int NUM_TERMS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cfg_mode_i,
    input  logic [NUM_TERMS-1:0] cfg_term_en_i,
    input  logic [NUM_TERMS-1:0] cfg_term_grp_i,
    input  logic                 cfg_invert_i,
    input  logic [1:0]           cfg_fb_sel_i,
    input  logic                 cfg_gate_pol_i,
    input  logic [NUM_TERMS-1:0] terms_i,
    input  logic                 ce_i,
    input  logic                 gate_i,
    input  logic                 arst_i,
    input  logic                 apre_i,
    input  logic                 srst_i,
    input  logic                 spre_i,
    input  logic                 oe_i,
    input  logic                 pad_i,
    output logic                 pin_o,
    output logic                 pin_oe_o,
    output logic                 fb_o
);
    logic sum_a;
    logic sum_b;
    logic q;

    term_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .terms_i (terms_i),
        .en_i    (cfg_term_en_i),
        .grp_i   (cfg_term_grp_i),
        .sum_a_o (sum_a),
        .sum_b_o (sum_b)
    );

    cell_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (cfg_mode_i),
        .gate_pol_i (cfg_gate_pol_i),
        .sum_a_i    (sum_a),
        .sum_b_i    (sum_b),
        .ce_i       (ce_i),
        .gate_i     (gate_i),
        .arst_i     (arst_i),
        .apre_i     (apre_i),
        .srst_i     (srst_i),
        .spre_i     (spre_i),
        .q_o        (q)
    );

    cell_out u_out (
        .mode_i   (cfg_mode_i),
        .invert_i (cfg_invert_i),
        .fb_sel_i (cfg_fb_sel_i),
        .sum_a_i  (sum_a),
        .q_i      (q),
        .oe_i     (oe_i),
        .pad_i    (pad_i),
        .pin_o    (pin_o),
        .pin_oe_o (pin_oe_o),
        .fb_o     (fb_o)
    );

    // R13
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o == oe_i));
endmodule

// File: tb/pld_out_cell_bench.sv
module pld_out_cell_bench;
    localparam int NT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode = 3'd1;
    logic [NT-1:0] ten = '0, tgrp = '0, terms = '0;
    logic inv = 1'b0, pol = 1'b1;
    logic [1:0] fbs = 2'd0;
    logic ce = 1'b0, gate = 1'b0, arst = 1'b1, apre = 1'b0;
    logic srst = 1'b0, spre = 1'b0, oe = 1'b0, pad = 1'b0;
    logic pin, pin_oe, fb;

    int checks = 0, fails = 0;
    logic m_ff = 1'b0, m_lat = 1'b0;
    logic prev_arst = 1'b1;

    always #5 clk = ~clk;

    pld_out_cell #(.NUM_TERMS(NT)) u_pld_out_cell (
        .clk(clk), .rst_n(rst_n), .cfg_mode_i(mode), .cfg_term_en_i(ten),
        .cfg_term_grp_i(tgrp), .cfg_invert_i(inv), .cfg_fb_sel_i(fbs),
        .cfg_gate_pol_i(pol), .terms_i(terms), .ce_i(ce), .gate_i(gate),
        .arst_i(arst), .apre_i(apre), .srst_i(srst), .spre_i(spre),
        .oe_i(oe), .pad_i(pad), .pin_o(pin), .pin_oe_o(pin_oe), .fb_o(fb)
    );

    function automatic logic sa();
        return |(terms & ten & ~tgrp);
    endfunction
    function automatic logic sb();
        return |(terms & ten & tgrp);
    endfunction
    function automatic logic clocked_m(input logic [2:0] m);
        return m >= 3'd1 && m <= 3'd4;
    endfunction
    function automatic logic nxt(input logic q, input logic a, input logic b);
        case (mode)
            3'd1: return a;
            3'd2: return q ^ a;
            3'd3: return b ? 1'b0 : (a ? 1'b1 : q);
            3'd4: return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
            default: return q;
        endcase
    endfunction
    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%b exp=%b t=%0t", req, what, got, exp, $time);
        end
    endtask

    task automatic level_model();
        if (arst) begin m_ff = 1'b0; m_lat = 1'b0; end
        else if (apre) begin m_ff = 1'b1; m_lat = 1'b1; end
        else if (mode == 3'd5 && gate == pol) m_lat = sa();
    endtask

    task automatic check_outs(input string req);
        logic q, epin, efb;
        q = (mode == 3'd5) ? m_lat : m_ff;
        epin = ((clocked_m(mode) || mode == 3'd5) ? q : sa()) ^ inv;
        case (fbs)
            2'd1: efb = pad;
            2'd2: efb = sa() ^ inv;
            default: efb = q;
        endcase
        chk(req, "pin", pin, epin);
        chk((fbs == 2'd0 || fbs == 2'd3) ? req : "R12", "fb", fb, efb);
        chk("R13", "oe", pin_oe, oe);
    endtask

    // Inputs are already set (after a negedge); check settle then the edge.
    task automatic cyc(input string req);
        level_model();
        #1 check_outs(req);
        @(posedge clk);
        if (arst) m_ff = 1'b0;
        else if (apre) m_ff = 1'b1;
        else if (!rst_n) m_ff = 1'b0;
        else if (srst) m_ff = 1'b0;
        else if (spre) m_ff = 1'b1;
        else if (ce) m_ff = nxt(m_ff, sa(), sb());
        level_model();
        #1 check_outs(req);
        prev_arst = arst;
        @(negedge clk);
    endtask

    task automatic reconfig(input logic [2:0] m, input logic [NT-1:0] e,
                            input logic [NT-1:0] g, input logic iv,
                            input logic [1:0] f, input logic p);
        arst = 1'b1; apre = 1'b0; srst = 1'b0; spre = 1'b0;
        mode = m; ten = e; tgrp = g; inv = iv; fbs = f; pol = p;
        cyc("R8");
        arst = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic exp_t;
        void'($urandom(32'd1234));
        @(negedge clk);
        // Reset state
        cyc("R8"); cyc("R9");
        rst_n = 1'b1;
        cyc("R8");
        chk("R8", "reset pin", pin, 1'b0);

        // R1: a disabled term has no effect, grouping splits sums
        reconfig(3'd0, 8'b0000_0011, 8'b0000_0010, 1'b0, 2'd2, 1'b1);
        oe = 1'b1; terms = 8'b1111_1100; cyc("R1");
        chk("R1", "disabled terms", pin, 1'b0);
        terms = 8'b0000_0001; cyc("R1");
        chk("R1", "enabled term", pin, 1'b1);
        // R2: codes 6 and 7 act as pass-through, with inverter R11
        reconfig(3'd6, 8'h01, 8'h00, 1'b1, 2'd0, 1'b1);
        terms = 8'h01; cyc("R2"); chk("R11", "inverted bypass", pin, 1'b0);
        reconfig(3'd7, 8'h01, 8'h00, 1'b0, 2'd1, 1'b1);
        pad = 1'b1; cyc("R2"); chk("R12", "pad feedback", fb, 1'b1);

        // R5: SR both high clears
        reconfig(3'd3, 8'h03, 8'h02, 1'b0, 2'd0, 1'b1);
        ce = 1'b1; terms = 8'h01; cyc("R5"); chk("R5", "set", pin, 1'b1);
        terms = 8'h03; cyc("R5"); chk("R5", "both clear", pin, 1'b0);
        // R6: JK both high toggles
        reconfig(3'd4, 8'h03, 8'h02, 1'b0, 2'd0, 1'b1);
        terms = 8'h03; cyc("R6"); chk("R6", "jk toggle1", pin, 1'b1);
        cyc("R6"); chk("R6", "jk toggle2", pin, 1'b0);
        // R9: srst over spre; spre over capture
        reconfig(3'd1, 8'h01, 8'h00, 1'b0, 2'd0, 1'b1);
        terms = 8'h01; srst = 1'b1; spre = 1'b1; cyc("R9");
        chk("R9", "srst wins", pin, 1'b0);
        srst = 1'b0; terms = 8'h00; cyc("R9"); chk("R9", "spre wins", pin, 1'b1);
        spre = 1'b0;
        // R10: ce low holds
        ce = 1'b0; cyc("R10"); cyc("R10"); chk("R10", "ce hold", pin, 1'b1);
        // R8: arst beats apre
        arst = 1'b1; apre = 1'b1; cyc("R8"); chk("R8", "arst wins", pin, 1'b0);
        arst = 1'b0; apre = 1'b0; cyc("R8");
        apre = 1'b1; cyc("R8"); chk("R8", "apre sets", pin, 1'b1);
        apre = 1'b0;
        // R7: latch, both gate polarities
        for (int p = 0; p < 2; p++) begin
            reconfig(3'd5, 8'h01, 8'h00, 1'b0, 2'd0, p[0]);
            gate = p[0]; terms = 8'h01; cyc("R7"); chk("R7", "open", pin, 1'b1);
            gate = ~p[0]; terms = 8'h00; srst = 1'b1; cyc("R7");
            chk("R7", "closed hold", pin, 1'b1);
            srst = 1'b0;
        end
        // R13: output disable
        oe = 1'b0; cyc("R13"); chk("R13", "oe low", pin_oe, 1'b0);
        oe = 1'b1;

        // R14: toggle through register feedback
        reconfig(3'd1, 8'h01, 8'h00, 1'b0, 2'd0, 1'b1);
        ce = 1'b1; exp_t = 1'b0;
        for (int i = 0; i < 10; i++) begin
            terms = {7'd0, ~fb & (i < 7)};
            cyc("R14");
            if (i < 7) exp_t = ~exp_t; else exp_t = 1'b0;
            chk("R14", "toggle pin", pin, exp_t);
        end

        // Random sweep under fixed seed
        for (int c = 0; c < 40; c++) begin
            reconfig(3'($urandom % 8), NT'($urandom), NT'($urandom),
                     1'($urandom), 2'($urandom), 1'($urandom));
            for (int k = 0; k < 60; k++) begin
                terms = NT'($urandom);
                ce = ($urandom % 4) != 0;
                gate = 1'($urandom);
                oe = 1'($urandom);
                pad = 1'($urandom);
                srst = ($urandom % 10) == 0;
                spre = ($urandom % 10) == 0;
                arst = ($urandom % 25) == 0;
                apre = !prev_arst && (($urandom % 25) == 0);
                rst_n = ($urandom % 40) != 0;
                cyc(tag_of(mode));
            end
            rst_n = 1'b1;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule